// File: doc/BRIEF.md
# Guest Control Register Loader

This block holds a small register file of guest control, paging-root, breakpoint-control, mode-extension and fast-system-call registers. When a one-cycle load strobe arrives, it commits a fresh set of values taken from its field inputs. Each register is written under its own rule. Some bits of the first control register keep their present value. Some bits of the breakpoint-control register are forced to fixed values. The 32-bit selector field is zero-extended. Both mode bits of the mode-extension register follow a single 64-bit-guest control input.

While it commits, the block compares the old and new values of the bits that affect address translation. In the cycle after the strobe it raises a translation-cache invalidate pulse if any of those bits changed. In the same cycle it raises a request to refetch the page-directory pointers when the new state selects the 32-bit extended-address paging form.

A small sequencer with two states produces both pulses:

- `ST_IDLE` is the quiet state.
- `ST_NOTIFY` is entered on every strobe and lasts one cycle.

The transitions are:

- idle→notify on a strobe.
- notify→notify on a strobe that follows directly.
- notify→idle when no strobe is present.

Top module: `gcr_loader`

## Requirements
- R1: After reset, `ctrl_a_q` is 0x10, `bkpt_q` is 0x400, every other register output is 0, and both pulses are low.
- R2: On a strobe, `ctrl_a_q` keeps its current value in bits 4, 6 to 15, 17 and 19 to 30 (mask 0x7FFAFFD0). All other bits take `ctrl_a_in`.
- R3: On a strobe, `bkpt_q` gets bits 12, 14 and 15 cleared and bit 10 set. All other bits take `bkpt_in`.
- R4: On a strobe, `ptroot_q`, `ctrl_b_q`, `dbg_cfg_q`, `sys_sp_q` and `sys_ip_q` copy their inputs in full.
- R5: On a strobe, `sys_sel_q[31:0]` takes `sys_sel_in` and `sys_sel_q[63:32]` is 0.
- R6: On a strobe, `mode_ext_q` bits 8 and 10 both equal `guest64_in`, and all its other bits are 0.
- R7: `tlb_flush_o` is high in the cycle after a strobe if any of these differs between the old and new values: paging root bits 63:5, `ctrl_b` bit 5 (extended addressing), `ctrl_b` bit 4 (large pages), or `mode_ext` bit 10.
- R8: Changes confined to paging root bits 4:0, or to `ctrl_b` bits other than 5 and 4, raise no invalidate pulse.
- R9: `pdpt_req_o` is high in the cycle after a strobe exactly when the new `ctrl_b` bit 5 is 1 and `guest64_in` is 0.
- R10: Both pulses last exactly one cycle. Without a strobe, every register output holds its value.
- R11: When strobes arrive on consecutive cycles, the second comparison uses the values committed by the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | One-cycle commit strobe |
| guest64_i | input | 1 | 64-bit-guest mode control |
| ctrl_a_in | input | 64 | First control register field |
| ptroot_in | input | 64 | Paging root field |
| ctrl_b_in | input | 64 | Second control register field |
| bkpt_in | input | 64 | Breakpoint-control field |
| sys_sel_in | input | 32 | Fast-call selector field |
| sys_sp_in | input | 64 | Fast-call stack field |
| sys_ip_in | input | 64 | Fast-call entry field |
| dbg_cfg_in | input | 64 | Debug configuration field |
| ctrl_a_q | output | 64 | Committed first control register |
| ptroot_q | output | 64 | Committed paging root |
| ctrl_b_q | output | 64 | Committed second control register |
| bkpt_q | output | 64 | Committed breakpoint control |
| mode_ext_q | output | 64 | Committed mode-extension register |
| sys_sel_q | output | 64 | Committed fast-call selector |
| sys_sp_q | output | 64 | Committed fast-call stack |
| sys_ip_q | output | 64 | Committed fast-call entry |
| dbg_cfg_q | output | 64 | Committed debug configuration |
| tlb_flush_o | output | 1 | Translation-cache invalidate pulse |
| pdpt_req_o | output | 1 | Pointer-table refetch request pulse |

## Verification
The hardest case to reach is a pair of strobes on adjacent cycles. There the second change test must compare against values that became visible only one edge earlier, while the sequencer stays in `ST_NOTIFY`. The bench holds the strobe high for two edges with different field sets. It picks the second set so that it differs from the first only in a bit that triggers invalidation, and it checks the pulse in each of the two following cycles. Loads that touch only paging root bits 4:0 or unrelated `ctrl_b` bits are sent on their own, to show that the invalidate pulse stays low.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam int GCR_XLEN    = 64;
    localparam int GCR_SELW    = 32;
    localparam int ROOT_LSB    = 5;
    localparam int PAE_BIT     = 5;
    localparam int PSE_BIT     = 4;
    localparam int LMA_BIT     = 10;
    localparam int LME_BIT     = 8;
    localparam int BK_ONE_BIT  = 10;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_NOTIFY = 1'b1
    } seq_state_t;

    // bit of the first control register that survives a commit
    function automatic bit ctrl_a_keep(input int idx);
        return (idx == 4) || (idx >= 6 && idx <= 15) || (idx == 17) ||
               (idx >= 19 && idx <= 30);
    endfunction

    // bit of breakpoint control that is written as zero
    function automatic bit bkpt_zero(input int idx);
        return (idx == 12) || (idx == 14) || (idx == 15);
    endfunction

endpackage

// File: rtl/gcr_ctrl_a_merge.sv
module gcr_ctrl_a_merge #(
    parameter int W = gcr_pkg::GCR_XLEN
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] nxt_i,
    output logic [W-1:0] merged_o
);
    import gcr_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (ctrl_a_keep(i)) begin : g_keep
            assign merged_o[i] = cur_i[i];
        end else begin : g_take
            assign merged_o[i] = nxt_i[i];
        end
    end

endmodule

// File: rtl/gcr_bkpt_force.sv
module gcr_bkpt_force #(
    parameter int W = gcr_pkg::GCR_XLEN
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] forced_o
);
    import gcr_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == BK_ONE_BIT) begin : g_one
            assign forced_o[i] = 1'b1;
        end else if (bkpt_zero(i)) begin : g_zero
            assign forced_o[i] = 1'b0;
        end else begin : g_pass
            assign forced_o[i] = raw_i[i];
        end
    end

endmodule

// File: rtl/gcr_flush_detect.sv
module gcr_flush_detect #(
    parameter int W = gcr_pkg::GCR_XLEN
) (
    input  logic [W-1:gcr_pkg::ROOT_LSB] old_root_i,
    input  logic [W-1:gcr_pkg::ROOT_LSB] new_root_i,
    input  logic                         old_pae_i,
    input  logic                         new_pae_i,
    input  logic                         old_pse_i,
    input  logic                         new_pse_i,
    input  logic                         old_lma_i,
    input  logic                         new_lma_i,
    output logic                         flush_o,
    output logic                         pdpt_o
);
    logic root_diff;
    logic mode_diff;

    always_comb begin
        root_diff = (old_root_i != new_root_i);
        mode_diff = (old_pae_i ^ new_pae_i) | (old_pse_i ^ new_pse_i) |
                    (old_lma_i ^ new_lma_i);
        flush_o   = root_diff | mode_diff;
        pdpt_o    = new_pae_i & ~new_lma_i;
    end

endmodule

// File: rtl/gcr_seq.sv
module gcr_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic flush_i,
    input  logic pdpt_i,
    output logic tlb_flush_o,
    output logic pdpt_req_o
);
    import gcr_pkg::*;

    seq_state_t state_q, state_d;
    logic       flush_flag_q;
    logic       pdpt_flag_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = load_i ? ST_NOTIFY : ST_IDLE;
            ST_NOTIFY: state_d = load_i ? ST_NOTIFY : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_flag_q <= 1'b0;
            pdpt_flag_q  <= 1'b0;
        end else if (load_i) begin
            flush_flag_q <= flush_i;
            pdpt_flag_q  <= pdpt_i;
        end
    end

    always_comb begin
        tlb_flush_o = (state_q == ST_NOTIFY) && flush_flag_q;
        pdpt_req_o  = (state_q == ST_NOTIFY) && pdpt_flag_q;
    end

    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_flush_o || pdpt_req_o) |-> $past(load_i));

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_flush_o && !load_i) |=> !tlb_flush_o);

endmodule

// File: rtl/gcr_loader.sv
module gcr_loader #(
    parameter int W    = gcr_pkg::GCR_XLEN,
    parameter int SELW = gcr_pkg::GCR_SELW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            guest64_i,
    input  logic [W-1:0]    ctrl_a_in,
    input  logic [W-1:0]    ptroot_in,
    input  logic [W-1:0]    ctrl_b_in,
    input  logic [W-1:0]    bkpt_in,
    input  logic [SELW-1:0] sys_sel_in,
    input  logic [W-1:0]    sys_sp_in,
    input  logic [W-1:0]    sys_ip_in,
    input  logic [W-1:0]    dbg_cfg_in,
    output logic [W-1:0]    ctrl_a_q,
    output logic [W-1:0]    ptroot_q,
    output logic [W-1:0]    ctrl_b_q,
    output logic [W-1:0]    bkpt_q,
    output logic [W-1:0]    mode_ext_q,
    output logic [W-1:0]    sys_sel_q,
    output logic [W-1:0]    sys_sp_q,
    output logic [W-1:0]    sys_ip_q,
    output logic [W-1:0]    dbg_cfg_q,
    output logic            tlb_flush_o,
    output logic            pdpt_req_o
);
    import gcr_pkg::*;

    localparam logic [W-1:0] CTRL_A_RST = W'(1) << 4;
    localparam logic [W-1:0] BKPT_RST   = W'(1) << BK_ONE_BIT;

    logic [W-1:0] ctrl_a_next;
    logic [W-1:0] bkpt_next;
    logic [W-1:0] mode_next;
    logic         flush_d;
    logic         pdpt_d;

    gcr_ctrl_a_merge #(.W(W)) u_merge (
        .cur_i    (ctrl_a_q),
        .nxt_i    (ctrl_a_in),
        .merged_o (ctrl_a_next)
    );

    gcr_bkpt_force #(.W(W)) u_force (
        .raw_i    (bkpt_in),
        .forced_o (bkpt_next)
    );

    gcr_flush_detect #(.W(W)) u_detect (
        .old_root_i (ptroot_q[W-1:ROOT_LSB]),
        .new_root_i (ptroot_in[W-1:ROOT_LSB]),
        .old_pae_i  (ctrl_b_q[PAE_BIT]),
        .new_pae_i  (ctrl_b_in[PAE_BIT]),
        .old_pse_i  (ctrl_b_q[PSE_BIT]),
        .new_pse_i  (ctrl_b_in[PSE_BIT]),
        .old_lma_i  (mode_ext_q[LMA_BIT]),
        .new_lma_i  (guest64_i),
        .flush_o    (flush_d),
        .pdpt_o     (pdpt_d)
    );

    gcr_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .flush_i     (flush_d),
        .pdpt_i      (pdpt_d),
        .tlb_flush_o (tlb_flush_o),
        .pdpt_req_o  (pdpt_req_o)
    );

    always_comb begin
        mode_next          = '0;
        mode_next[LMA_BIT] = guest64_i;
        mode_next[LME_BIT] = guest64_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a_q   <= CTRL_A_RST;
            ptroot_q   <= '0;
            ctrl_b_q   <= '0;
            bkpt_q     <= BKPT_RST;
            mode_ext_q <= '0;
            sys_sel_q  <= '0;
            sys_sp_q   <= '0;
            sys_ip_q   <= '0;
            dbg_cfg_q  <= '0;
        end else if (load_i) begin
            ctrl_a_q   <= ctrl_a_next;
            ptroot_q   <= ptroot_in;
            ctrl_b_q   <= ctrl_b_in;
            bkpt_q     <= bkpt_next;
            mode_ext_q <= mode_next;
            sys_sel_q  <= {{(W-SELW){1'b0}}, sys_sel_in};
            sys_sp_q   <= sys_sp_in;
            sys_ip_q   <= sys_ip_in;
            dbg_cfg_q  <= dbg_cfg_in;
        end
    end

    p_ctrl_a_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ctrl_a_q[30:19] == $past(ctrl_a_q[30:19]) &&
                   ctrl_a_q[15:6]  == $past(ctrl_a_q[15:6]) &&
                   ctrl_a_q[17]    == $past(ctrl_a_q[17]) &&
                   ctrl_a_q[4]     == $past(ctrl_a_q[4]));

    p_bkpt_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> bkpt_q[10] && !bkpt_q[12] && !bkpt_q[14] && !bkpt_q[15]);

    p_sel_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_sel_q[W-1:SELW] == '0);

    p_mode_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> mode_ext_q[LMA_BIT] == $past(guest64_i) &&
                   mode_ext_q[LME_BIT] == $past(guest64_i));

    p_pdpt_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pdpt_req_o |-> ctrl_b_q[PAE_BIT] && !mode_ext_q[LMA_BIT]);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(ptroot_q) && $stable(ctrl_b_q) && $stable(ctrl_a_q) &&
                    $stable(bkpt_q) && $stable(mode_ext_q));

endmodule

// File: tb/sim_gcr_loader.sv
module sim_gcr_loader;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] KEEP_A = 64'h0000_0000_7FFA_FFD0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        guest64_i = 1'b0;
    logic [63:0] ctrl_a_in = '0, ptroot_in = '0, ctrl_b_in = '0, bkpt_in = '0;
    logic [31:0] sys_sel_in = '0;
    logic [63:0] sys_sp_in = '0, sys_ip_in = '0, dbg_cfg_in = '0;
    logic [63:0] ctrl_a_q, ptroot_q, ctrl_b_q, bkpt_q, mode_ext_q;
    logic [63:0] sys_sel_q, sys_sp_q, sys_ip_q, dbg_cfg_q;
    logic        tlb_flush_o, pdpt_req_o;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of committed state
    logic [63:0] m_a = 64'h10, m_root = '0, m_b = '0, m_lma = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcr_loader u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .guest64_i(guest64_i),
        .ctrl_a_in(ctrl_a_in), .ptroot_in(ptroot_in), .ctrl_b_in(ctrl_b_in),
        .bkpt_in(bkpt_in), .sys_sel_in(sys_sel_in), .sys_sp_in(sys_sp_in),
        .sys_ip_in(sys_ip_in), .dbg_cfg_in(dbg_cfg_in),
        .ctrl_a_q(ctrl_a_q), .ptroot_q(ptroot_q), .ctrl_b_q(ctrl_b_q),
        .bkpt_q(bkpt_q), .mode_ext_q(mode_ext_q), .sys_sel_q(sys_sel_q),
        .sys_sp_q(sys_sp_q), .sys_ip_q(sys_ip_q), .dbg_cfg_q(dbg_cfg_q),
        .tlb_flush_o(tlb_flush_o), .pdpt_req_o(pdpt_req_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_fields(input logic g64, input logic [63:0] a, input logic [63:0] root,
                              input logic [63:0] b, input logic [63:0] bk);
        guest64_i = g64; ctrl_a_in = a; ptroot_in = root; ctrl_b_in = b; bkpt_in = bk;
        sys_sel_in = root[31:0] ^ 32'hA5A5_0F0F;
        sys_sp_in  = ~root;
        sys_ip_in  = {a[31:0], b[31:0]};
        dbg_cfg_in = bk ^ 64'h1234_5678_9ABC_DEF0;
    endtask

    // called at the negedge after a load edge: checks registers and pulses
    task automatic check_commit(input string tag);
        logic [63:0] lma_new;
        logic        exp_flush, exp_pdpt;
        lma_new   = {63'd0, guest64_i};
        exp_flush = (m_root[63:5] != ptroot_in[63:5]) || (m_b[5] != ctrl_b_in[5]) ||
                    (m_b[4] != ctrl_b_in[4]) || (m_lma[0] != guest64_i);
        exp_pdpt  = ctrl_b_in[5] && !guest64_i;
        m_a    = (m_a & KEEP_A) | (ctrl_a_in & ~KEEP_A);
        m_root = ptroot_in; m_b = ctrl_b_in; m_lma = lma_new;
        chk({"R2 ", tag}, ctrl_a_q, m_a);
        chk({"R3 ", tag}, bkpt_q, (bkpt_in & ~64'hD000) | 64'h400);
        chk({"R4 ", tag}, ptroot_q, ptroot_in);
        chk({"R4 ", tag}, ctrl_b_q, ctrl_b_in);
        chk({"R4 ", tag}, sys_sp_q ^ sys_ip_q ^ dbg_cfg_q, sys_sp_in ^ sys_ip_in ^ dbg_cfg_in);
        chk({"R5 ", tag}, sys_sel_q, {32'd0, sys_sel_in});
        chk({"R6 ", tag}, mode_ext_q, guest64_i ? 64'h500 : 64'h0);
        chk({"R7 ", tag}, {63'd0, tlb_flush_o}, {63'd0, exp_flush});
        chk({"R9 ", tag}, {63'd0, pdpt_req_o}, {63'd0, exp_pdpt});
    endtask

    task automatic do_load(input string tag);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        check_commit(tag);
        @(negedge clk);
        chk({"R10 pulse end ", tag}, {62'd0, tlb_flush_o, pdpt_req_o}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 ctrl_a", ctrl_a_q, 64'h10);
        chk("R1 bkpt", bkpt_q, 64'h400);
        chk("R1 others", ptroot_q | ctrl_b_q | mode_ext_q | sys_sel_q |
                         sys_sp_q | sys_ip_q | dbg_cfg_q, 64'd0);
        chk("R1 pulses", {62'd0, tlb_flush_o, pdpt_req_o}, 64'd0);
    endtask

    task automatic t_all_ones;
        set_fields(1'b0, '1, 64'hFFFF_0000_1234_5000, 64'h0000_0000_0000_0020, '1);
        sys_sel_in = 32'hFFFF_FFFF;
        do_load("all-ones");
    endtask

    task automatic t_zeros;
        set_fields(1'b0, '0, 64'hFFFF_0000_1234_5000, 64'h20, '0);
        do_load("zeros");
    endtask

    task automatic t_low_root_only;  // R8
        set_fields(1'b0, 64'hDEAD_BEEF_0000_0001, 64'hFFFF_0000_1234_501F, 64'hFFFF_FF20, 64'h0F0F);
        do_load("R8 low root bits");
    endtask

    task automatic t_root_bit5;  // R7
        set_fields(1'b0, 64'h5, 64'hFFFF_0000_1234_503F, 64'hFFFF_FF20, 64'hAAAA);
        do_load("R7 root bit5");
    endtask

    task automatic t_pse_toggle;  // R7, R9 no request
        set_fields(1'b0, 64'h5, 64'hFFFF_0000_1234_503F, 64'hFFFF_FF10, 64'h5555);
        do_load("R7 pse/pae");
    endtask

    task automatic t_guest64;  // R6, R7 lma change, R9 suppressed
        set_fields(1'b1, 64'h8000_0001, 64'hFFFF_0000_1234_503F, 64'hFFFF_FF30, 64'h0);
        do_load("R6 guest64");
        set_fields(1'b1, 64'h8000_0001, 64'hFFFF_0000_1234_503F, 64'hFFFF_FF30, 64'h0);
        do_load("R8 repeat no change");
    endtask

    task automatic t_hold;  // R10
        logic [63:0] snap;
        snap = ptroot_q ^ ctrl_a_q ^ bkpt_q ^ sys_sel_q ^ mode_ext_q;
        set_fields(1'b0, '1, 64'h1111_2222_3333_4444, 64'h20, '1);
        repeat (3) @(negedge clk);
        chk("R10 hold", ptroot_q ^ ctrl_a_q ^ bkpt_q ^ sys_sel_q ^ mode_ext_q, snap);
        chk("R10 no pulse", {62'd0, tlb_flush_o, pdpt_req_o}, 64'd0);
    endtask

    task automatic t_back_to_back;  // R11
        set_fields(1'b0, 64'h3, 64'h0000_0000_0000_1000, 64'h20, 64'h1);
        load_i = 1'b1;
        @(negedge clk);
        check_commit("R11 first");
        set_fields(1'b0, 64'h3, 64'h0000_0000_0000_1000, 64'h30, 64'h1);
        @(negedge clk);
        load_i = 1'b0;
        check_commit("R11 second pse");
        @(negedge clk);
        chk("R11 pulse end", {62'd0, tlb_flush_o, pdpt_req_o}, 64'd0);
        set_fields(1'b0, 64'h3, 64'h0000_0000_0000_1000, 64'h30, 64'h1);
        load_i = 1'b1;
        @(negedge clk);
        check_commit("R11 identical first");
        @(negedge clk);
        load_i = 1'b0;
        check_commit("R11 identical second");
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_ones();
        t_zeros();
        t_low_root_only();
        t_root_bit5();
        t_pse_toggle();
        t_guest64();
        t_hold();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule